// File: doc/BRIEF.md
# Ethernet Receive Frame Status Checker

This block sits in an Ethernet receive path, right after the stage that turns media-independent-interface nibbles into octets. Each incoming octet arrives with a valid strobe. Start-of-frame and end-of-frame markers ride on the first and last octets. With the last octet comes a 3-bit count of leftover bits that did not make a whole octet. The block passes octets on toward the receive FIFO and runs a CRC-32 over every whole octet. It counts the frame length and compares it with two limits: a programmable oversize limit and a fixed 2047-byte truncation limit.

When a frame ends, the block produces one status word. The word carries five flags (overrun, non-octet, CRC error, too long, truncated) and the saturated byte count. When a frame first grows past the programmable limit, a one-cycle babbling-receive interrupt pulse is raised. A FIFO-full input stands in for a full receive FIFO. An octet that arrives while FIFO-full is high is dropped. If FIFO-full is high when the frame ends, the status word waits until space returns.

Top module: `rx_frame_checker`

## Requirements
- R1: The CRC is CRC-32 with polynomial 0x04C11DB7, shifted in reflected form (LSB first), starting from all ones, and it covers every octet of the frame including the FCS. The FCS is the inverted CRC of the preceding octets, sent least significant byte first. A correct frame leaves 0xDEBB20E3 in the reflected register and then raises no CRC or non-octet flag. Status and written octets each appear one clock after the octet that causes them.
- R2: If the CRC check fails and the dribble count is 0, the CRC-error flag is set and the non-octet flag is clear.
- R3: The dribble count (1 to 7) never enters the CRC. If the CRC check fails and the dribble count is nonzero, the non-octet flag is set and the CRC-error flag is clear. If the check passes, neither flag is set, whatever the dribble count.
- R4: The too-long flag is set when the frame length in octets exceeds `max_len_i` as sampled on the start-of-frame octet. Changes to `max_len_i` later in the frame have no effect. Octets beyond that limit are still written.
- R5: `babble_irq_o` pulses for exactly one cycle, once per frame, one clock after the first octet whose position exceeds the sampled limit.
- R6: Octets beyond position 2047 are not written, the truncated flag is set, and the reported count saturates at 2047.
- R7: An octet that arrives while `fifo_full_i` is high is not written, and the frame's status carries the overrun flag.
- R8: If `fifo_full_i` is high when the frame ends, the status is held back and is emitted, with its flags intact, one clock after `fifo_full_i` is seen low.
- R9: All flags and the count restart at each start-of-frame, so no flag from a previous frame appears in the next status.
- R10: After reset, `wr_valid_o`, `stat_valid_o` and `babble_irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Octet strobe |
| rx_sof_i | input | 1 | Octet is the first of a frame |
| rx_eof_i | input | 1 | Octet is the last of a frame |
| rx_data_i | input | 8 | Received octet |
| rx_dribble_i | input | 3 | Leftover bit count, valid with end of frame |
| fifo_full_i | input | 1 | Receive FIFO has no space |
| max_len_i | input | 11 | Programmable oversize limit in octets |
| wr_valid_o | output | 1 | Octet write strobe toward the FIFO |
| wr_data_o | output | 8 | Octet written toward the FIFO |
| stat_valid_o | output | 1 | Status word strobe |
| stat_ovr_o | output | 1 | Overrun flag |
| stat_nonoct_o | output | 1 | Non-octet error flag |
| stat_crc_o | output | 1 | CRC error flag |
| stat_long_o | output | 1 | Frame-too-long flag |
| stat_trunc_o | output | 1 | Truncated flag |
| stat_count_o | output | 11 | Frame byte count, saturating at 2047 |
| babble_irq_o | output | 1 | Babbling-receive interrupt pulse |

## Verification
The hardest case to reach from the ports is the truncation boundary. The frame must go past 2047 octets while also crossing the oversize limit, and the FCS must stay correct, so the bench must generate frames of 2046 to 2050 octets with a valid CRC. The bench builds each frame with a computed FCS and sweeps the length across that boundary. It also sweeps small frame lengths against small oversize limits, every dribble count against good and corrupted CRCs, and FIFO-full windows that cover the end of the frame and hold the status back.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
  localparam int OCT_W = 8;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE  = 32'hDEBB20E3;

  typedef struct packed {
    logic ovr;
    logic nonoct;
    logic crc;
    logic long_f;
    logic trunc;
  } rx_flags_t;

  function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c_in,
                                                 input logic [OCT_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = c_in ^ {{(CRC_W-OCT_W){1'b0}}, d};
    for (int b = 0; b < OCT_W; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxchk_crc.sv
module rxchk_crc
  import rxchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic [OCT_W-1:0] data_i,
  output logic             crc_good_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_base   = sof_i ? CRC_SEED : crc_q;
    crc_d      = crc_octet(crc_base, data_i);
    crc_good_o = (crc_d == CRC_RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (beat_i) begin
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/rxchk_len.sv
module rxchk_len #(
  parameter int          LEN_W   = 11,
  parameter logic [LEN_W-1:0] MAX_RST = 11'd1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic [LEN_W-1:0] count_o,
  output logic             long_o,
  output logic             trunc_o,
  output logic             babble_o,
  output logic             drop_o
);
  localparam logic [LEN_W-1:0] LEN_LIMIT = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, max_q, eff_max;
  logic             long_q, trunc_q;
  logic [LEN_W:0]   raw_len;
  logic             long_prev, trunc_prev, long_now;

  always_comb begin
    eff_max    = sof_i ? max_len_i : max_q;
    raw_len    = sof_i ? {{LEN_W{1'b0}}, 1'b1} : ({1'b0, cnt_q} + 1'b1);
    long_prev  = sof_i ? 1'b0 : long_q;
    trunc_prev = sof_i ? 1'b0 : trunc_q;
    long_now   = raw_len > {1'b0, eff_max};
    drop_o     = beat_i && !sof_i && (cnt_q == LEN_LIMIT);
    babble_o   = beat_i && long_now && !long_prev;
    long_o     = long_prev | long_now;
    trunc_o    = trunc_prev | drop_o;
    count_o    = drop_o ? LEN_LIMIT : raw_len[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      max_q   <= MAX_RST;
      long_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else if (beat_i) begin
      cnt_q   <= count_o;
      max_q   <= eff_max;
      long_q  <= long_o;
      trunc_q <= trunc_o;
    end
  end
endmodule

// File: rtl/rxchk_stat.sv
module rxchk_stat
  import rxchk_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int DRIB_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              full_i,
  input  logic [DRIB_W-1:0] dribble_i,
  input  logic              crc_good_i,
  input  logic              long_i,
  input  logic              trunc_i,
  input  logic [LEN_W-1:0]  count_i,
  output logic              stat_valid_o,
  output rx_flags_t         flags_o,
  output logic [LEN_W-1:0]  count_o
);
  logic      ovr_q, ovr_d;
  logic      pend_q, pend_d;
  logic      sv_d;
  logic      close;
  rx_flags_t flags_d;

  always_comb begin
    close = beat_i && eof_i;
    ovr_d = (sof_i ? 1'b0 : ovr_q) | full_i;
    flags_d.ovr    = ovr_d;
    flags_d.nonoct = !crc_good_i && (dribble_i != '0);
    flags_d.crc    = !crc_good_i && (dribble_i == '0);
    flags_d.long_f = long_i;
    flags_d.trunc  = trunc_i;
    if (close) begin
      sv_d   = !full_i;
      pend_d = full_i;
    end else begin
      sv_d   = pend_q && !full_i;
      pend_d = pend_q && full_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q        <= 1'b0;
      pend_q       <= 1'b0;
      stat_valid_o <= 1'b0;
    end else begin
      if (beat_i) ovr_q <= ovr_d;
      pend_q       <= pend_d;
      stat_valid_o <= sv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      count_o <= '0;
    end else if (close) begin
      flags_o <= flags_d;
      count_o <= count_i;
    end
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rxchk_pkg::*;
#(
  parameter int               LEN_W   = 11,
  parameter int               DRIB_W  = 3,
  parameter logic [LEN_W-1:0] MAX_RST = 11'd1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic [DRIB_W-1:0] rx_dribble_i,
  input  logic              fifo_full_i,
  input  logic [LEN_W-1:0]  max_len_i,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              stat_valid_o,
  output logic              stat_ovr_o,
  output logic              stat_nonoct_o,
  output logic              stat_crc_o,
  output logic              stat_long_o,
  output logic              stat_trunc_o,
  output logic [LEN_W-1:0]  stat_count_o,
  output logic              babble_irq_o
);
  logic             crc_good;
  logic [LEN_W-1:0] len_count;
  logic             len_long, len_trunc, len_babble, len_drop;
  logic             wr_en_d;
  rx_flags_t        flags;

  rxchk_crc u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_i     (rx_valid_i),
    .sof_i      (rx_sof_i),
    .data_i     (rx_data_i),
    .crc_good_o (crc_good)
  );

  rxchk_len #(.LEN_W(LEN_W), .MAX_RST(MAX_RST)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_i    (rx_valid_i),
    .sof_i     (rx_sof_i),
    .max_len_i (max_len_i),
    .count_o   (len_count),
    .long_o    (len_long),
    .trunc_o   (len_trunc),
    .babble_o  (len_babble),
    .drop_o    (len_drop)
  );

  rxchk_stat #(.LEN_W(LEN_W), .DRIB_W(DRIB_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_i       (rx_valid_i),
    .sof_i        (rx_sof_i),
    .eof_i        (rx_eof_i),
    .full_i       (fifo_full_i),
    .dribble_i    (rx_dribble_i),
    .crc_good_i   (crc_good),
    .long_i       (len_long),
    .trunc_i      (len_trunc),
    .count_i      (len_count),
    .stat_valid_o (stat_valid_o),
    .flags_o      (flags),
    .count_o      (stat_count_o)
  );

  always_comb begin
    wr_en_d = rx_valid_i && !fifo_full_i && !len_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_o   <= 1'b0;
      babble_irq_o <= 1'b0;
    end else begin
      wr_valid_o   <= wr_en_d;
      babble_irq_o <= len_babble;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data_o <= '0;
    end else if (wr_en_d) begin
      wr_data_o <= rx_data_i;
    end
  end

  assign stat_ovr_o    = flags.ovr;
  assign stat_nonoct_o = flags.nonoct;
  assign stat_crc_o    = flags.crc;
  assign stat_long_o   = flags.long_f;
  assign stat_trunc_o  = flags.trunc;
endmodule

// File: rtl/rxchk_props.sv
module rxchk_props #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid_i,
  input logic             rx_sof_i,
  input logic             fifo_full_i,
  input logic             wr_valid_o,
  input logic             stat_valid_o,
  input logic             stat_nonoct_o,
  input logic             stat_crc_o,
  input logic             stat_long_o,
  input logic             stat_trunc_o,
  input logic [LEN_W-1:0] stat_count_o,
  input logic             babble_irq_o
);
  localparam logic [LEN_W-1:0] LIM = {LEN_W{1'b1}};
  logic [LEN_W:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (rx_valid_i && rx_sof_i) begin
      wcnt_q <= '0;
    end else if (wr_valid_o) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(rx_valid_i && !fifo_full_i)); // R7
  AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wcnt_q < {1'b0, LIM})); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> !(stat_crc_o && stat_nonoct_o)); // R3
  AST_TRUNC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid_o && stat_trunc_o) |-> (stat_long_o && stat_count_o == LIM)); // R6
  AST_STAT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> $past(!fifo_full_i)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    babble_irq_o |=> !babble_irq_o); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    babble_irq_o |-> $past(rx_valid_i)); // R5
endmodule

bind rx_frame_checker rxchk_props #(.LEN_W(LEN_W)) u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid_i    (rx_valid_i),
  .rx_sof_i      (rx_sof_i),
  .fifo_full_i   (fifo_full_i),
  .wr_valid_o    (wr_valid_o),
  .stat_valid_o  (stat_valid_o),
  .stat_nonoct_o (stat_nonoct_o),
  .stat_crc_o    (stat_crc_o),
  .stat_long_o   (stat_long_o),
  .stat_trunc_o  (stat_trunc_o),
  .stat_count_o  (stat_count_o),
  .babble_irq_o  (babble_irq_o)
);

// File: tb/sim_rx_frame_checker.sv
module sim_rx_frame_checker;
  localparam int CLK_P = 10;
  localparam int LIMIT = 2047;

  logic        clk, rst_n;
  logic        rx_valid_i, rx_sof_i, rx_eof_i, fifo_full_i;
  logic [7:0]  rx_data_i;
  logic [2:0]  rx_dribble_i;
  logic [10:0] max_len_i;
  logic        wr_valid_o, stat_valid_o, stat_ovr_o, stat_nonoct_o, stat_crc_o;
  logic        stat_long_o, stat_trunc_o, babble_irq_o;
  logic [7:0]  wr_data_o;
  logic [10:0] stat_count_o;

  int checks, failures;
  int wr_n, wr_sum, irq_n, st_seen;
  logic [10:0] st_cnt;
  logic st_ovr, st_no, st_crc, st_long, st_tr;
  logic [7:0] fr [0:2099];

  rx_frame_checker u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i),
    .rx_eof_i(rx_eof_i), .rx_data_i(rx_data_i), .rx_dribble_i(rx_dribble_i),
    .fifo_full_i(fifo_full_i), .max_len_i(max_len_i), .wr_valid_o(wr_valid_o),
    .wr_data_o(wr_data_o), .stat_valid_o(stat_valid_o), .stat_ovr_o(stat_ovr_o),
    .stat_nonoct_o(stat_nonoct_o), .stat_crc_o(stat_crc_o), .stat_long_o(stat_long_o),
    .stat_trunc_o(stat_trunc_o), .stat_count_o(stat_count_o), .babble_irq_o(babble_irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid_o) begin wr_n++; wr_sum += int'(wr_data_o); end
      if (babble_irq_o) irq_n++;
      if (stat_valid_o) begin
        st_seen++;
        st_cnt = stat_count_o; st_ovr = stat_ovr_o; st_no = stat_nonoct_o;
        st_crc = stat_crc_o; st_long = stat_long_o; st_tr = stat_trunc_o;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tb_crc(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if ((c[0] ^ d[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
      else                       c = c >> 1;
    end
    return c;
  endfunction

  task automatic build(input int len, input bit bad, input int seed);
    logic [31:0] c;
    int n;
    n = len - 4;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      fr[i] = 8'((i * 37 + seed) & 255);
      c = tb_crc(c, fr[i]);
    end
    c = ~c;
    for (int b = 0; b < 4; b++) fr[n + b] = c[8*b +: 8];
    if (bad) fr[0] = fr[0] ^ 8'h01;
  endtask

  // len: total octets incl. FCS; full during octets [fs,fe); hold: cycles full after end
  task automatic send(input int len, input bit bad, input int drib, input int maxl,
                      input int maxchg, input int fs, input int fe, input int hold,
                      input string tag);
    int e_wr, e_sum, e_cnt;
    bit e_long, e_tr, e_ovr;
    build(len, bad, len + drib);
    wr_n = 0; wr_sum = 0; irq_n = 0; st_seen = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid_i   = 1'b1;
      rx_sof_i     = (i == 0);
      rx_eof_i     = (i == len - 1);
      rx_data_i    = fr[i];
      rx_dribble_i = (i == len - 1) ? 3'(drib) : 3'd0;
      fifo_full_i  = (i >= fs) && (i < fe);
      max_len_i    = (i == 0 || maxchg < 0) ? 11'(maxl) : 11'(maxchg);
      @(negedge clk);
    end
    rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0; rx_dribble_i = 3'd0;
    if (hold > 0) begin
      fifo_full_i = 1'b1;
      repeat (hold) @(negedge clk);
      #1;
      chk(st_seen == 0, "R8", {tag, " status held while full"}, st_seen, 0);
    end
    fifo_full_i = 1'b0;
    @(negedge clk);
    #1;
    e_wr = 0; e_sum = 0;
    for (int i = 0; i < len; i++)
      if (i < LIMIT && !(i >= fs && i < fe)) begin e_wr++; e_sum += int'(fr[i]); end
    e_cnt  = (len > LIMIT) ? LIMIT : len;
    e_long = len > maxl;
    e_tr   = len > LIMIT;
    e_ovr  = (fs < fe) && (fs < len);
    chk(st_seen == 1, "R1", {tag, " status count"}, st_seen, 1);
    chk(st_cnt == 11'(e_cnt), "R6", {tag, " byte count"}, int'(st_cnt), e_cnt);
    chk(st_crc == (bad && drib == 0), "R2", {tag, " crc flag"}, int'(st_crc), int'(bad && drib == 0));
    chk(st_no == (bad && drib != 0), "R3", {tag, " non-octet flag"}, int'(st_no), int'(bad && drib != 0));
    chk(st_long == e_long, "R4", {tag, " long flag"}, int'(st_long), int'(e_long));
    chk(st_tr == e_tr, "R6", {tag, " trunc flag"}, int'(st_tr), int'(e_tr));
    chk(st_ovr == e_ovr, "R7", {tag, " overrun flag"}, int'(st_ovr), int'(e_ovr));
    chk(wr_n == e_wr, "R7", {tag, " octets written"}, wr_n, e_wr);
    chk(wr_sum == e_sum, "R4", {tag, " written data sum"}, wr_sum, e_sum);
    chk(irq_n == int'(e_long), "R5", {tag, " babble pulses"}, irq_n, int'(e_long));
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    wr_n = 0; wr_sum = 0; irq_n = 0; st_seen = 0;
    rst_n = 1'b0; rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0;
    rx_data_i = 8'd0; rx_dribble_i = 3'd0; fifo_full_i = 1'b0; max_len_i = 11'd1518;
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_valid_o && !stat_valid_o && !babble_irq_o, "R10", "outputs after reset",
        int'({wr_valid_o, stat_valid_o, babble_irq_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: every dribble count against good and corrupted CRC
    for (int d = 0; d < 8; d++) begin
      send(64, 1'b0, d, 1518, -1, 0, 0, 0, "R3 good");
      send(64, 1'b1, d, 1518, -1, 0, 0, 0, "R2/R3 bad");
    end

    // R4 R5: length sweep against small limits
    for (int m = 6; m <= 10; m++)
      for (int l = 5; l <= 12; l++)
        send(l, 1'b0, 0, m, -1, 0, 0, 0, "R4 sweep");

    // R4: limit changes after start of frame are ignored
    send(20, 1'b0, 0, 30, 5, 0, 0, 0, "R4 late max low");
    send(20, 1'b0, 0, 10, 1000, 0, 0, 0, "R4 late max high");

    // R6: truncation boundary
    for (int l = 2046; l <= 2050; l++)
      send(l, 1'b0, 0, 1518, -1, 0, 0, 0, "R6 trunc");

    // R9: clean frame after a frame with every error condition
    send(2049, 1'b1, 3, 100, -1, 5, 9, 0, "R9 dirty");
    send(30, 1'b0, 0, 1518, -1, 0, 0, 0, "R9 clean");

    // R7: overrun window mid-frame
    send(20, 1'b0, 0, 1518, -1, 3, 6, 0, "R7 mid");
    send(20, 1'b0, 0, 1518, -1, 0, 1, 0, "R7 first");

    // R8: full through the end of frame, status waits for space
    send(24, 1'b1, 0, 16, -1, 20, 24, 4, "R8 hold");
    send(24, 1'b0, 5, 1518, -1, 23, 24, 1, "R8 hold1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule